// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Unit

This unit observes a processor's instruction stream and data-access stream and requests debug exceptions when either touches an address that a debugger has programmed. There are four independent slots. Each slot holds a base address and a control word. The control word selects whether the slot is enabled, what kind of activity it watches (execution, stores only, or loads and stores), and how many bytes it covers (1, 2 or 4).

An execution match is reported combinationally, in the same cycle the instruction address is presented. This is a fault-style request: the core takes it before the instruction runs and restarts that instruction after the handler. A data match is reported one cycle after the access. This is a trap-style request: the access has already completed and is not replayed. A sticky per-slot status vector records which slots hit.

A resume flag lets a handler return to an instruction that carries an execution breakpoint without hitting it again. The flag is controlled by a two-state machine:
- `RS_ARMED` is the flag-clear state.
- `RS_MUTED` is the flag-set state.
- The load transition fires when `rf_load` is pulsed. It moves to `RS_MUTED` if `rf_value` is 1 and to `RS_ARMED` if it is 0.
- The retire transition goes from `RS_MUTED` to `RS_ARMED` when a presented instruction retires.

While the machine is in `RS_MUTED`, execution matches are masked and data matches are not.

Top module: `dbg_watch_unit`

## Requirements
- R1: Slots are programmed through the write port.
  - `cfg_addr` 0..3 loads the base address of slot 0..3.
  - `cfg_addr` 4..7 loads the control word of slot 0..3:
    - bit 0: enable.
    - bits 2:1: kind. 00 = execute, 01 = store only, 11 = load or store, and 10 never matches.
    - bits 4:3: length. 00 = 1 byte, 01 = 2 bytes, 11 = 4 bytes.
  - The slot's range starts at its base aligned down to its length.
- R2: With `inst_valid` high, an enabled execute slot whose range contains `inst_addr` drives `ibrk_req` high in the same cycle.
- R3: A disabled slot never matches. An execute slot ignores data accesses, and a data slot ignores instruction addresses.
- R4: A store-only slot matches only accesses with `data_write` high. A load-or-store slot matches both directions.
- R5: An access covers 1, 2 or 4 bytes starting at `data_addr`. The size is given by `data_size`: 00 = 1, 01 = 2, 10 = 4. Any byte of the access that overlaps a data slot's range is a hit, and it raises `dbrk_req` in the cycle after the access.
- R6: A cycle with `rf_load` high sets `resume_flag` to `rf_value` from the next cycle on.
- R7: While `resume_flag` is high, `ibrk_req` stays low and execute hits are not recorded. The flag clears after the first cycle with `inst_valid` and `inst_retire` both high, so the following instruction can break again.
- R8: A set `resume_flag` does not mask data hits, `dbrk_req`, or their status bits.
- R9: `hit_status` bit i is set by a hit in slot i and stays set. An execute hit appears in the cycle after `ibrk_req`. Data hits appear together with `dbrk_req`. All slots that hit in the same cycle are recorded together.
- R10: A write to `cfg_addr` 8 clears each status bit written as 0 and keeps each bit written as 1. A hit in the same cycle as that write wins.
- R11: After reset `ibrk_req`, `dbrk_req`, `hit_status` and `resume_flag` are all 0, and every slot is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select (bases, controls, status) |
| cfg_wdata | input | 32 | Register write data |
| inst_valid | input | 1 | An instruction address is presented |
| inst_retire | input | 1 | The presented instruction completes this cycle |
| inst_addr | input | 32 | Address of the instruction about to run |
| data_valid | input | 1 | A data access completes this cycle |
| data_write | input | 1 | 1 = store, 0 = load |
| data_size | input | 2 | Access size code |
| data_addr | input | 32 | First byte address of the access |
| rf_load | input | 1 | Exception-return strobe that loads the resume flag |
| rf_value | input | 1 | Saved resume flag value |
| ibrk_req | output | 1 | Fault-style instruction breakpoint request |
| dbrk_req | output | 1 | Trap-style data breakpoint request |
| hit_status | output | 4 | Sticky per-slot hit bits |
| resume_flag | output | 1 | Current resume flag |

## Verification
The assertions assume that the core never retires an instruction in a cycle where `ibrk_req` is high. They also assume that `inst_retire` is only meaningful together with `inst_valid`, and that `data_size` code 11 is not driven. The stimulus drives retire only on instructions that are not breaking or are muted, and uses only the three defined size codes. Accesses are placed away from the top of the address space, so the overlap window never wraps.

// File: rtl/dbg_watch_pkg.sv
`timescale 1ns/1ps
package dbg_watch_pkg;

    typedef enum logic [1:0] {
        KIND_EXEC  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_NONE  = 2'b10,
        KIND_RDWR  = 2'b11
    } watch_kind_e;

    typedef enum logic {
        RS_ARMED = 1'b0,
        RS_MUTED = 1'b1
    } resume_state_e;

    // control word layout: [4:3] length, [2:1] kind, [0] enable
    typedef struct packed {
        logic [1:0]  len;
        watch_kind_e kind;
        logic        en;
    } slot_ctrl_t;

    localparam int CTRL_W = $bits(slot_ctrl_t);

endpackage

// File: rtl/dbg_watch_slot.sv
`timescale 1ns/1ps
module dbg_watch_slot
    import dbg_watch_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CFG_AW    = 4,
    parameter int BASE_ADDR = 0,
    parameter int CTRL_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic [AW-1:0]     inst_addr,
    input  logic [AW-1:0]     data_first,
    input  logic [AW:0]       data_last,
    input  logic              data_write,
    output logic              exec_match,
    output logic              data_match
);

    logic [AW-1:0] base_q;
    slot_ctrl_t    ctrl_q;
    logic [AW-1:0] keep_mask;
    logic [AW-1:0] range_lo;
    logic [AW:0]   range_hi;
    logic          dir_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ctrl_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(BASE_ADDR)) base_q <= cfg_wdata;
            if (cfg_addr == CFG_AW'(CTRL_ADDR)) ctrl_q <= slot_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        keep_mask  = ~{{(AW-2){1'b0}}, ctrl_q.len};
        range_lo   = base_q & keep_mask;
        range_hi   = {1'b0, range_lo} | {{(AW-1){1'b0}}, ctrl_q.len};
        dir_ok     = (ctrl_q.kind == KIND_RDWR) ||
                     ((ctrl_q.kind == KIND_WRITE) && data_write);
        exec_match = ctrl_q.en && (ctrl_q.kind == KIND_EXEC) &&
                     ((inst_addr & keep_mask) == range_lo);
        data_match = ctrl_q.en && dir_ok &&
                     ({1'b0, data_first} <= range_hi) &&
                     ({1'b0, range_lo} <= data_last);
    end

endmodule

// File: rtl/dbg_resume_fsm.sv
`timescale 1ns/1ps
module dbg_resume_fsm
    import dbg_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rf_load,
    input  logic rf_value,
    input  logic inst_done,
    output logic muted
);

    resume_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_ARMED: if (rf_load && rf_value) state_d = RS_MUTED;
            RS_MUTED: begin
                if (rf_load)        state_d = rf_value ? RS_MUTED : RS_ARMED;
                else if (inst_done) state_d = RS_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        muted = (state_q == RS_MUTED);
    end

endmodule

// File: rtl/dbg_watch_unit.sv
`timescale 1ns/1ps
module dbg_watch_unit
    import dbg_watch_pkg::*;
#(
    parameter  int AW        = 32,
    parameter  int NUM_SLOTS = 4,
    localparam int CFG_AW    = $clog2(2 * NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [AW-1:0]        cfg_wdata,
    input  logic                 inst_valid,
    input  logic                 inst_retire,
    input  logic [AW-1:0]        inst_addr,
    input  logic                 data_valid,
    input  logic                 data_write,
    input  logic [1:0]           data_size,
    input  logic [AW-1:0]        data_addr,
    input  logic                 rf_load,
    input  logic                 rf_value,
    output logic                 ibrk_req,
    output logic                 dbrk_req,
    output logic [NUM_SLOTS-1:0] hit_status,
    output logic                 resume_flag
);

    localparam int STATUS_ADDR = 2 * NUM_SLOTS;

    logic [NUM_SLOTS-1:0] exec_hits, data_hits, exec_rec, data_rec, status_kept;
    logic [NUM_SLOTS-1:0] status_q;
    logic [AW:0]          data_last;
    logic                 muted, dbrk_q;

    always_comb begin
        data_last = {1'b0, data_addr} +
                    (data_size[1] ? (AW+1)'(3) : (data_size[0] ? (AW+1)'(1) : '0));
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dbg_watch_slot #(
            .AW(AW), .CFG_AW(CFG_AW),
            .BASE_ADDR(s), .CTRL_ADDR(NUM_SLOTS + s)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
            .inst_addr(inst_addr), .data_first(data_addr), .data_last(data_last),
            .data_write(data_write),
            .exec_match(exec_hits[s]), .data_match(data_hits[s])
        );
    end

    dbg_resume_fsm u_resume (
        .clk(clk), .rst_n(rst_n),
        .rf_load(rf_load), .rf_value(rf_value),
        .inst_done(inst_valid && inst_retire),
        .muted(muted)
    );

    always_comb begin
        exec_rec    = (inst_valid && !muted) ? exec_hits : '0;
        data_rec    = data_valid ? data_hits : '0;
        status_kept = (cfg_we && cfg_addr == CFG_AW'(STATUS_ADDR))
                    ? (status_q & cfg_wdata[NUM_SLOTS-1:0]) : status_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            dbrk_q   <= 1'b0;
        end else begin
            status_q <= status_kept | exec_rec | data_rec;
            dbrk_q   <= |data_rec;
        end
    end

    always_comb begin
        ibrk_req    = |exec_rec;
        dbrk_req    = dbrk_q;
        hit_status  = status_q;
        resume_flag = muted;
    end

endmodule

// File: rtl/dbg_watch_unit_chk.sv
`timescale 1ns/1ps
module dbg_watch_unit_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int CFG_AW    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [CFG_AW-1:0]    cfg_addr,
    input logic                 inst_valid,
    input logic                 inst_retire,
    input logic                 data_valid,
    input logic                 rf_load,
    input logic                 rf_value,
    input logic                 ibrk_req,
    input logic                 dbrk_req,
    input logic [NUM_SLOTS-1:0] hit_status,
    input logic                 resume_flag
);

    localparam int STATUS_ADDR = 2 * NUM_SLOTS;

    // R2
    ibrk_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ibrk_req |-> inst_valid);

    // R7
    muted_no_ibrk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_flag |-> !ibrk_req);

    // R7
    flag_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_flag && inst_valid && inst_retire && !rf_load) |=> !resume_flag);

    // R6
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_load |=> (resume_flag == $past(rf_value)));

    // R5
    dbrk_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbrk_req |-> $past(data_valid));

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == CFG_AW'(STATUS_ADDR))
        |=> (($past(hit_status) & ~hit_status) == '0));

    // R9
    dbrk_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbrk_req |-> (hit_status != '0));

endmodule

bind dbg_watch_unit dbg_watch_unit_chk #(
    .NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .inst_valid(inst_valid), .inst_retire(inst_retire), .data_valid(data_valid),
    .rf_load(rf_load), .rf_value(rf_value), .ibrk_req(ibrk_req),
    .dbrk_req(dbrk_req), .hit_status(hit_status), .resume_flag(resume_flag)
);

// File: tb/dbg_watch_unit_bench.sv
`timescale 1ns/1ps
module dbg_watch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        inst_valid = 1'b0, inst_retire = 1'b0;
    logic [31:0] inst_addr = '0;
    logic        data_valid = 1'b0, data_write = 1'b0;
    logic [1:0]  data_size = '0;
    logic [31:0] data_addr = '0;
    logic        rf_load = 1'b0, rf_value = 1'b0;
    logic        ibrk_req, dbrk_req, resume_flag;
    logic [3:0]  hit_status;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_watch_unit u_dbg_watch_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .inst_valid(inst_valid), .inst_retire(inst_retire),
        .inst_addr(inst_addr), .data_valid(data_valid), .data_write(data_write),
        .data_size(data_size), .data_addr(data_addr), .rf_load(rf_load),
        .rf_value(rf_value), .ibrk_req(ibrk_req), .dbrk_req(dbrk_req),
        .hit_status(hit_status), .resume_flag(resume_flag)
    );

    // {is_data, write, size, addr, exp_ibrk, exp_dbrk, exp_status}
    localparam int NV = 12;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'b00, 32'h0000_1000, 1'b1, 1'b0, 4'b0001},
        {1'b0, 1'b0, 2'b00, 32'h0000_1001, 1'b0, 1'b0, 4'b0000},
        {1'b0, 1'b0, 2'b00, 32'h0000_2000, 1'b0, 1'b0, 4'b0000},
        {1'b1, 1'b1, 2'b10, 32'h0000_2000, 1'b0, 1'b1, 4'b1010},
        {1'b1, 1'b0, 2'b00, 32'h0000_2000, 1'b0, 1'b0, 4'b0000},
        {1'b1, 1'b0, 2'b00, 32'h0000_3003, 1'b0, 1'b1, 4'b0100},
        {1'b1, 1'b1, 2'b01, 32'h0000_3001, 1'b0, 1'b1, 4'b0100},
        {1'b1, 1'b0, 2'b01, 32'h0000_3000, 1'b0, 1'b0, 4'b0000},
        {1'b1, 1'b1, 2'b01, 32'h0000_1FFF, 1'b0, 1'b1, 4'b0010},
        {1'b1, 1'b0, 2'b10, 32'h0000_1000, 1'b0, 1'b0, 4'b0000},
        {1'b0, 1'b0, 2'b00, 32'h0000_3002, 1'b0, 1'b0, 4'b0000},
        {1'b1, 1'b1, 2'b10, 32'h0000_2004, 1'b0, 1'b0, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply(input logic isd, input logic wr, input logic [1:0] sz,
                         input logic [31:0] a, output logic ib, output logic db,
                         output logic [3:0] st);
        @(negedge clk);
        if (isd) begin
            data_valid = 1'b1; data_write = wr; data_size = sz; data_addr = a;
        end else begin
            inst_valid = 1'b1; inst_addr = a;
        end
        #2 ib = ibrk_req;
        @(posedge clk);
        #1 db = dbrk_req; st = hit_status;
        @(negedge clk);
        data_valid = 1'b0; inst_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ib, db;
        logic [3:0] st;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R11 ibrk", ibrk_req, 0);
        chk("R11 dbrk", dbrk_req, 0);
        chk("R11 status", hit_status, 0);
        chk("R11 flag", resume_flag, 0);
        apply(1'b0, 1'b0, 2'b00, 32'h0, ib, db, st);
        chk("R11 slots disabled ibrk", ib, 0);
        chk("R11 slots disabled status", st, 0);

        // R1 programming: bases then controls {len,kind,en}
        cfg_write(4'd0, 32'h1000);
        cfg_write(4'd1, 32'h2000);
        cfg_write(4'd2, 32'h3003);
        cfg_write(4'd3, 32'h2003);
        cfg_write(4'd4, 32'b00_00_1);
        cfg_write(4'd5, 32'b11_01_1);
        cfg_write(4'd6, 32'b01_11_1);
        cfg_write(4'd7, 32'b00_11_1);

        for (int i = 0; i < NV; i++) begin
            cfg_write(4'd8, 32'h0);
            apply(VEC[i][41], VEC[i][40], VEC[i][39:38], VEC[i][37:6], ib, db, st);
            chk(VEC[i][41] ? "R5 vec ibrk" : "R2 vec ibrk", ib, VEC[i][5]);
            chk(VEC[i][41] ? "R4 vec dbrk" : "R3 vec dbrk", db, VEC[i][4]);
            chk("R9 vec status", st, VEC[i][3:0]);
        end

        // R3: disabled slot never matches
        cfg_write(4'd4, 32'b00_00_0);
        apply(1'b0, 1'b0, 2'b00, 32'h1000, ib, db, st);
        chk("R3 disabled ibrk", ib, 0);
        cfg_write(4'd4, 32'b00_00_1);

        // R6/R7/R8: resume flag
        cfg_write(4'd8, 32'h0);
        @(negedge clk); rf_load = 1'b1; rf_value = 1'b1;
        @(negedge clk); rf_load = 1'b0;
        chk("R6 flag loaded", resume_flag, 1);
        inst_valid = 1'b1; inst_addr = 32'h1000; inst_retire = 1'b0;
        data_valid = 1'b1; data_write = 1'b1; data_size = 2'b10; data_addr = 32'h2000;
        #2 chk("R7 muted ibrk", ibrk_req, 0);
        @(posedge clk); #1;
        chk("R8 dbrk while muted", dbrk_req, 1);
        chk("R8 status while muted", hit_status, 4'b1010);
        chk("R7 flag holds without retire", resume_flag, 1);
        @(negedge clk); data_valid = 1'b0; inst_retire = 1'b1;
        @(posedge clk); #1;
        chk("R7 flag cleared by retire", resume_flag, 0);
        @(negedge clk); inst_retire = 1'b0;
        #2 chk("R7 rearmed ibrk", ibrk_req, 1);
        @(negedge clk); inst_valid = 1'b0;

        // R6: load of value 0
        @(negedge clk); rf_load = 1'b1; rf_value = 1'b1;
        @(negedge clk); rf_value = 1'b0;
        @(negedge clk); rf_load = 1'b0;
        chk("R6 flag loaded zero", resume_flag, 0);

        // R10: selective clear and hit wins
        cfg_write(4'd8, 32'h0);
        apply(1'b1, 1'b1, 2'b10, 32'h2000, ib, db, st);
        apply(1'b0, 1'b0, 2'b00, 32'h1000, ib, db, st);
        chk("R9 accumulated", hit_status, 4'b1011);
        cfg_write(4'd8, 32'b1110);
        chk("R10 selective clear", hit_status, 4'b1010);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 32'h0;
        inst_valid = 1'b1; inst_addr = 32'h1000;
        @(posedge clk); #1;
        chk("R10 hit wins over clear", hit_status, 4'b0001);
        @(negedge clk); cfg_we = 1'b0; inst_valid = 1'b0;

        // R1: kind code 10 never matches
        cfg_write(4'd7, 32'b00_10_1);
        cfg_write(4'd8, 32'h0);
        apply(1'b1, 1'b1, 2'b00, 32'h2003, ib, db, st);
        chk("R1 kind 10 inert status", st, 4'b0010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule